// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It runs on the fast oscillator clock and emits one single-cycle pulse for every V·N + A input cycles. Internally, a prescaler divides by either V or V+1. A swallow counter holds the prescaler at V+1 for the first A prescaler periods of each output cycle. A program counter ends the output cycle after N prescaler periods. With A anywhere from 0 to V−1 and N > A, every integer ratio from V·V upward can be reached in steps of one.

V is fixed when the block is built. N and A are run-time inputs. They are sampled only on the input cycle where the program counter wraps, so the settings can be changed at any time without corrupting a cycle that is already running. A sampled pair is illegal when N is not greater than A, or when A is not below V. An illegal pair raises an error flag, and the divider runs the next output cycle with the fallback setting N = V, A = 0.

Top module: `swallow_divider`

## Requirements
- R1: After synchronous reset, `div_out`, `mod_ctl` and `cfg_err` are 0. The first output cycle uses the fallback setting (N = V, A = 0): `div_out` is first high on the V·V-th rising edge after reset is released.
- R2: For a legal sampled pair (N > A and A < V), the distance between successive `div_out` pulses is V·N + A input cycles.
- R3: Within each output cycle, `mod_ctl` (1 = divide by V+1) is high for exactly A·(V+1) input cycles. Those cycles form one contiguous run that starts in the cycle where `div_out` is high, and `mod_ctl` is low for the rest of the output cycle.
- R4: When the sampled A is 0, `mod_ctl` stays low for the whole output cycle.
- R5: `div_out` is high for exactly one input cycle per output cycle.
- R6: `n_in` and `a_in` are used only on the edge that also raises `div_out`. Changes at any other time have no effect on the output cycle in progress.
- R7: A sampled pair with N ≤ A sets `cfg_err`. The next output cycle then lasts V·V input cycles with `mod_ctl` low throughout.
- R8: A sampled pair with A ≥ V sets `cfg_err` and uses the same fallback as R7.
- R9: `cfg_err` changes only on the edge that raises `div_out`. It shows the legality of the most recently sampled pair, so a legal pair clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| n_in | input | N_W | Program count N, sampled at cycle wrap |
| a_in | input | A_W | Swallow count A, sampled at cycle wrap |
| div_out | output | 1 | One-cycle pulse per output cycle |
| mod_ctl | output | 1 | Prescaler modulus select: 1 = V+1, 0 = V |
| cfg_err | output | 1 | Last sampled N/A pair was illegal |

## Verification
The hardest case to reach is a change of settings that lands mid-cycle and must stay invisible until the next wrap. The stimulus handles this in three steps after each pulse. It drives the pair intended for the following cycle, then overwrites it with unrelated values for a few cycles, then restores it well before the wrap. Every measured period must still match the pair that was present at the wrap edge. Illegal pairs of both kinds are placed between legal ones, so that each shows the error flag being raised and then cleared on the next legal sample. The shortest ratio (N = 1, A = 0) is included, which gives a cycle only V input clocks long.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

    // Prescaler modulus selection driven by the swallow counter.
    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by V
        MOD_PLUS = 1'b1    // divide by V+1
    } modsel_e;

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import swallow_pkg::*;
#(
    parameter int V = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  modsel_e msel,
    output logic    tc
);

    localparam int PW = $clog2(V + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PW-1:0] last_val;

    always_comb begin
        st_d     = st_q;
        last_val = (msel == MOD_PLUS) ? PW'(V) : PW'(V - 1);
        tc       = (st_q.cnt == last_val);
        if (tc) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
    import swallow_pkg::*;
#(
    parameter int A_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           restart,
    input  logic [A_W-1:0] limit,
    output modsel_e        msel
);

    typedef struct packed {
        logic [A_W-1:0] cnt;
    } swl_st_t;

    swl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        msel = (st_q.cnt < limit) ? MOD_PLUS : MOD_BASE;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick && (msel == MOD_PLUS)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_program.sv
module psd_program #(
    parameter int V   = 64,
    parameter int N_W = 12,
    parameter int A_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    output logic           wrap,
    output logic [A_W-1:0] a_cur,
    output logic           err,
    output logic           pulse
);

    localparam int CW = ((N_W > A_W) ? N_W : A_W) + 1;
    localparam logic [N_W-1:0] DEF_N = N_W'(V);

    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic [N_W-1:0] n_lim;
        logic [A_W-1:0] a_lim;
        logic           err;
        logic           pulse;
    } prg_st_t;

    prg_st_t st_d, st_q;
    logic    legal;

    always_comb begin
        st_d  = st_q;
        legal = (CW'(n_in) > CW'(a_in)) && (CW'(a_in) < CW'(V));
        wrap  = tick && (st_q.cnt == (st_q.n_lim - 1'b1));

        st_d.pulse = wrap;
        if (wrap) begin
            st_d.cnt = '0;
            if (legal) begin
                st_d.n_lim = n_in;
                st_d.a_lim = a_in;
                st_d.err   = 1'b0;
            end else begin
                st_d.n_lim = DEF_N;
                st_d.a_lim = '0;
                st_d.err   = 1'b1;
            end
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.n_lim <= DEF_N;
            st_q.a_lim <= '0;
            st_q.err   <= 1'b0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_cur = st_q.a_lim;
    assign err   = st_q.err;
    assign pulse = st_q.pulse;

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swallow_pkg::*;
#(
    parameter int V   = 64,
    parameter int N_W = 12,
    parameter int A_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    output logic           div_out,
    output logic           mod_ctl,
    output logic           cfg_err
);

    modsel_e        msel;
    logic           pre_tc;
    logic           wrap;
    logic [A_W-1:0] a_cur;

    psd_prescaler #(.V(V)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .msel (msel),
        .tc   (pre_tc)
    );

    psd_swallow #(.A_W(A_W)) u_swl (
        .clk     (clk),
        .rst     (rst),
        .tick    (pre_tc),
        .restart (wrap),
        .limit   (a_cur),
        .msel    (msel)
    );

    psd_program #(.V(V), .N_W(N_W), .A_W(A_W)) u_prg (
        .clk   (clk),
        .rst   (rst),
        .tick  (pre_tc),
        .n_in  (n_in),
        .a_in  (a_in),
        .wrap  (wrap),
        .a_cur (a_cur),
        .err   (cfg_err),
        .pulse (div_out)
    );

    assign mod_ctl = (msel == MOD_PLUS);

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk (
    input logic clk,
    input logic rst,
    input logic div_out,
    input logic mod_ctl,
    input logic cfg_err
);

    logic seen_rst = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rst <= 1'b1;
        end
    end

    // R1: outputs idle right after a reset cycle
    p_reset_idle_r1: assert property (@(posedge clk)
        (seen_rst && $past(rst)) |-> (!div_out && !mod_ctl && !cfg_err));

    // R5: the output pulse is one cycle wide
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // R3: the V+1 run may only begin at the start of an output cycle
    p_mod_starts_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_ctl) |-> div_out);

    // R7: an illegal setting never selects V+1
    p_mod_legal_r7: assert property (@(posedge clk) disable iff (rst)
        mod_ctl |-> !cfg_err);

    // R9: the error flag moves only at a cycle boundary
    p_err_held_r9: assert property (@(posedge clk) disable iff (rst)
        !div_out |-> $stable(cfg_err));

endmodule

bind swallow_divider swallow_divider_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .div_out (div_out),
    .mod_ctl (mod_ctl),
    .cfg_err (cfg_err)
);

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;

    localparam int V   = 8;
    localparam int N_W = 8;
    localparam int A_W = 5;
    localparam int NCFG = 10;

    typedef struct {
        int    len;
        int    mhi;
        bit    err;
        string tag_len;
        string tag_mod;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N_W-1:0] n_in = '0;
    logic [A_W-1:0] a_in = '0;
    logic           div_out;
    logic           mod_ctl;
    logic           cfg_err;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_run  = 1'b0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    int cfg_n [NCFG] = '{8, 10, 9, 1, 5, 12, 20, 3, 0, 30};
    int cfg_a [NCFG] = '{0,  3, 7, 0, 5,  4,  9, 2, 0,  0};

    swallow_divider #(.V(V), .N_W(N_W), .A_W(A_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .n_in    (n_in),
        .a_in    (a_in),
        .div_out (div_out),
        .mod_ctl (mod_ctl),
        .cfg_err (cfg_err)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic exp_t make_exp(input int n, input int a);
        exp_t e;
        bit legal;
        legal = (n > a) && (a < V);
        e.len = legal ? (V * n + a) : (V * V);
        e.mhi = legal ? (a * (V + 1)) : 0;
        e.err = !legal;
        if (!legal) e.tag_len = (a >= V) ? "R8" : "R7";
        else        e.tag_len = "R2/R6";
        e.tag_mod = (a == 0) ? "R4" : "R3";
        return e;
    endfunction

    task automatic wait_pulse();
        do @(negedge clk); while (!div_out);
    endtask

    // Monitor: measures each output cycle and compares with the scoreboard
    initial begin
        int   cnt = 0;
        int   mhi = 0;
        bit   err_cap = 1'b0;
        bit   low_seen = 1'b0;
        bit   broken = 1'b0;
        bit   started = 1'b0;
        bit   prev_out = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_run) begin
                if (div_out && prev_out) begin
                    check(1'b0, "R5", 2, 1);
                end
                if (div_out) begin
                    if (started) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R2", cnt, -1);
                        end else begin
                            e = exp_q.pop_front();
                            check(cnt == e.len, e.tag_len, cnt, e.len);
                            check(mhi == e.mhi, e.tag_mod, mhi, e.mhi);
                            check(!broken, "R3", int'(broken), 0);
                            check(err_cap == e.err, "R9", int'(err_cap), int'(e.err));
                        end
                    end
                    started  = 1'b1;
                    cnt      = 1;
                    mhi      = mod_ctl ? 1 : 0;
                    err_cap  = cfg_err;
                    low_seen = !mod_ctl;
                    broken   = 1'b0;
                end else if (started) begin
                    cnt++;
                    if (mod_ctl) begin
                        mhi++;
                        if (low_seen) broken = 1'b1;
                    end else begin
                        low_seen = 1'b1;
                    end
                end
                prev_out = div_out;
            end
        end
    end

    // Driver
    initial begin
        int first_len;
        n_in = N_W'(cfg_n[0]);
        a_in = A_W'(cfg_a[0]);
        rst  = 1'b1;
        repeat (3) @(negedge clk);
        check(!div_out && !mod_ctl && !cfg_err, "R1",
              int'({div_out, mod_ctl, cfg_err}), 0);
        rst = 1'b0;
        mon_run = 1'b1;
        first_len = 0;
        do begin
            @(negedge clk);
            first_len++;
        end while (!div_out && first_len < 10000);
        check(first_len == V * V, "R1", first_len, V * V);
        exp_q.push_back(make_exp(cfg_n[0], cfg_a[0]));
        for (int i = 1; i < NCFG; i++) begin
            n_in = N_W'(cfg_n[i]);
            a_in = A_W'(cfg_a[i]);
            // R6: unrelated values mid-cycle, restored before the wrap
            repeat (2) @(negedge clk);
            n_in = N_W'(7 + 13 * i);
            a_in = A_W'(3 * i + 1);
            repeat (2) @(negedge clk);
            n_in = N_W'(cfg_n[i]);
            a_in = A_W'(cfg_a[i]);
            wait_pulse();
            exp_q.push_back(make_exp(cfg_n[i], cfg_a[i]));
        end
        wait_pulse();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2: watchdog expired, actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule